// File: doc/BRIEF.md
# Scaler Initial Phase Generator

This block produces the starting filter phase word for one axis of a polyphase image scaler. It takes the scale factor for that axis (source size over destination size, unsigned 16.16 fixed point), a subsampling factor of 1 (luma or RGB) or 2 (half-rate chroma), and a flag that asks for co-sited chroma placement. It returns a 16-bit word that holds a trip bit and a truncated phase fraction. It also raises a flag when the computed phase falls outside the window the filter hardware accepts.

The phase is measured from the top-left edge of the first source pixel, not from its centre. The arithmetic therefore starts at minus one half. Co-siting moves the chroma sample a quarter pixel when the subsampling factor is 2. Half of the per-output step, divided by the subsampling factor, is always added. A negative result wraps by one whole pixel and leaves the trip bit clear. A result of zero or more sets the trip bit.

By default the result is registered: an input sample marked valid gives a result one clock later. A parameter selects a purely combinational variant instead.

Top module: `scaler_phase_gen`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld_o`, `range_err_o` and `sub_err_o` are 0 and `phase_o` is 16'h0000 until the first valid input.
- R2: In the registered variant, an input accepted with `in_vld_i` high at a rising edge appears on the outputs after that edge, with `out_vld_o` high for exactly that one cycle. `out_vld_o` is low after any edge at which `in_vld_i` was low.
- R3: The internal phase value v is -0x8000 + floor(scale / (2*s)), where s is the subsampling factor and 0x10000 stands for one pixel.
- R4: With `cosite_i` high and s = 2, 0x4000 is added to v. With s = 1, `cosite_i` has no effect.
- R5: When v is negative, bit 15 of `phase_o` (the trip bit) is 0 and bits 14:0 equal bits 16:2 of (0x10000 + v).
- R6: When v is zero or positive, bit 15 of `phase_o` is 1 and bits 14:0 equal bits 16:2 of v.
- R7: `range_err_o` is 1 exactly when v < -0x8000 or v > 0x18000. The boundaries themselves are legal.
- R8: `sub_i` encodes s directly: 2'd1 means 1 and 2'd2 means 2. For 2'd0 or 2'd3, `sub_err_o` is 1 and the arithmetic uses s = 1, with no co-site offset.
- R9: A 4:1 downscale (scale 0x40000, s = 1, no co-site) gives 16'hE000. A 1:4 upscale (scale 0x4000, s = 1) gives 16'h2800.
- R10: In the registered variant, `phase_o`, `range_err_o` and `sub_err_o` keep their values across cycles in which `in_vld_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input sample valid |
| scale_i | input | 32 | Scale factor, unsigned 16.16 |
| sub_i | input | 2 | Subsampling factor (1 or 2) |
| cosite_i | input | 1 | Request co-sited chroma offset |
| phase_o | output | 16 | Trip bit (15) and phase fraction (14:0) |
| out_vld_o | output | 1 | Result valid |
| range_err_o | output | 1 | Phase outside the legal window |
| sub_err_o | output | 1 | Subsampling code not 1 or 2 |

## Verification
The properties assume the registered variant and an input valid strobe that is low during reset. They place no other limit on the inputs. Scale values up to the full 32-bit range and all four subsampling codes are treated as legal stimulus, because the block reports rather than rejects bad combinations. The random stimulus weights the scale factor toward the region around one to four pixels, where the trip bit and the upper window edge change. It still sends occasional full-range values and illegal subsampling codes so that both error flags are exercised. The valid strobe is toggled at random so that the hold behaviour is covered as well.

// File: rtl/scaler_phase_pkg.sv
package scaler_phase_pkg;
   typedef enum logic [1:0] {
      SUB_BAD0 = 2'd0,
      SUB_ONE  = 2'd1,
      SUB_TWO  = 2'd2,
      SUB_BAD3 = 2'd3
   } sub_code_e;

   typedef struct packed {
      logic oor;
      logic sub_bad;
   } phase_flags_t;
endpackage

// File: rtl/phs_accum.sv
module phs_accum #(
   parameter int SCALE_W = 32,
   parameter int FRAC_W  = 16,
   parameter int ACC_W   = SCALE_W + 2
) (
   input  logic [SCALE_W-1:0]     scale_i,
   input  logic [1:0]             sub_i,
   input  logic                   cosite_i,
   output logic signed [ACC_W-1:0] acc_o,
   output logic                   sub_bad_o
);
   import scaler_phase_pkg::*;

   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);
   localparam logic signed [ACC_W-1:0] QUARTER = ACC_W'(1) << (FRAC_W - 2);

   initial begin
      if (ACC_W < SCALE_W + 2) $error("phs_accum: ACC_W too narrow");
      if (FRAC_W < 2) $error("phs_accum: FRAC_W too small");
   end

   logic                    halve_sub;
   logic signed [ACC_W-1:0] scale_term;
   logic signed [ACC_W-1:0] site_term;

   always_comb begin
      halve_sub  = (sub_code_e'(sub_i) == SUB_TWO);
      sub_bad_o  = (sub_code_e'(sub_i) != SUB_ONE) && !halve_sub;
      scale_term = halve_sub ? $signed({2'b00, scale_i} >> 2)
                             : $signed({2'b00, scale_i} >> 1);
      site_term  = (halve_sub && cosite_i) ? QUARTER : '0;
      acc_o      = scale_term + site_term - HALF;
   end
endmodule

// File: rtl/phs_window.sv
module phs_window #(
   parameter int ACC_W  = 34,
   parameter int FRAC_W = 16
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic                    oor_o
);
   localparam logic signed [ACC_W-1:0] LOW_LIM  = -($signed(ACC_W'(1) << (FRAC_W - 1)));
   localparam logic signed [ACC_W-1:0] HIGH_LIM = $signed(ACC_W'(3) << (FRAC_W - 1));

   always_comb oor_o = (acc_i < LOW_LIM) || (acc_i > HIGH_LIM);
endmodule

// File: rtl/phs_encode.sv
module phs_encode #(
   parameter int ACC_W  = 34,
   parameter int FRAC_W = 16,
   parameter int OUT_W  = 16
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic [OUT_W-1:0]        word_o
);
   localparam int FIELD_W = OUT_W - 1;
   localparam int DROP    = FRAC_W + 1 - FIELD_W;
   localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

   initial begin
      if (DROP < 0) $error("phs_encode: OUT_W too wide for FRAC_W");
      if (DROP + FIELD_W > ACC_W) $error("phs_encode: field exceeds accumulator");
   end

   logic                    neg;
   logic signed [ACC_W-1:0] wrapped;

   always_comb begin
      neg     = acc_i[ACC_W-1];
      wrapped = neg ? (acc_i + ONE) : acc_i;
      word_o  = {~neg, wrapped[DROP +: FIELD_W]};
   end
endmodule

// File: rtl/scaler_phase_gen.sv
module scaler_phase_gen #(
   parameter int SCALE_W = 32,
   parameter int FRAC_W  = 16,
   parameter int OUT_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               in_vld_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [1:0]         sub_i,
   input  logic               cosite_i,
   output logic [OUT_W-1:0]   phase_o,
   output logic               out_vld_o,
   output logic               range_err_o,
   output logic               sub_err_o
);
   import scaler_phase_pkg::*;

   localparam int ACC_W = SCALE_W + 2;

   initial begin
      if (SCALE_W <= FRAC_W) $error("scaler_phase_gen: SCALE_W must exceed FRAC_W");
      if (OUT_W < 2) $error("scaler_phase_gen: OUT_W too small");
   end

   logic signed [ACC_W-1:0] acc;
   logic [OUT_W-1:0]        word;
   phase_flags_t            flags;

   phs_accum #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) accum_i (
      .scale_i  (scale_i),
      .sub_i    (sub_i),
      .cosite_i (cosite_i),
      .acc_o    (acc),
      .sub_bad_o(flags.sub_bad)
   );

   phs_window #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) window_i (
      .acc_i(acc),
      .oor_o(flags.oor)
   );

   phs_encode #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) encode_i (
      .acc_i (acc),
      .word_o(word)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic [OUT_W-1:0] word_q;
         phase_flags_t     flags_q;
         logic             vld_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               word_q  <= '0;
               flags_q <= '0;
               vld_q   <= 1'b0;
            end else begin
               vld_q <= in_vld_i;
               if (in_vld_i) begin
                  word_q  <= word;
                  flags_q <= flags;
               end
            end
         end

         assign phase_o     = word_q;
         assign range_err_o = flags_q.oor;
         assign sub_err_o   = flags_q.sub_bad;
         assign out_vld_o   = vld_q;
      end else begin : g_comb
         assign phase_o     = in_vld_i ? word : '0;
         assign range_err_o = in_vld_i & flags.oor;
         assign sub_err_o   = in_vld_i & flags.sub_bad;
         assign out_vld_o   = in_vld_i;
      end
   endgenerate
endmodule

// File: rtl/scaler_phase_gen_chk.sv
module scaler_phase_gen_chk #(
   parameter int SCALE_W = 32,
   parameter int FRAC_W  = 16,
   parameter int OUT_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               in_vld_i,
   input logic [SCALE_W-1:0] scale_i,
   input logic [1:0]         sub_i,
   input logic               cosite_i,
   input logic [OUT_W-1:0]   phase_o,
   input logic               out_vld_o,
   input logic               range_err_o,
   input logic               sub_err_o
);
   localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << FRAC_W;

   generate
      if (REG_OUT) begin : g_props
         // R2
         a_r2_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
            in_vld_i |=> out_vld_o);
         // R2
         a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !in_vld_i |=> !out_vld_o);
         // R8
         a_r8_sub_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
            in_vld_i |=> (sub_err_o == ($past(sub_i) != 2'd1 && $past(sub_i) != 2'd2)));
         // R7
         a_r7_unity_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_vld_i && scale_i <= UNITY) |=> !range_err_o);
         // R5
         a_r5_trip_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_vld_i && sub_i == 2'd1 && scale_i < UNITY) |=> !phase_o[OUT_W-1]);
         // R10
         a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !in_vld_i |=> ($stable(phase_o) && $stable(range_err_o) && $stable(sub_err_o)));
      end
   endgenerate
endmodule

bind scaler_phase_gen scaler_phase_gen_chk #(
   .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .REG_OUT(REG_OUT)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .in_vld_i   (in_vld_i),
   .scale_i    (scale_i),
   .sub_i      (sub_i),
   .cosite_i   (cosite_i),
   .phase_o    (phase_o),
   .out_vld_o  (out_vld_o),
   .range_err_o(range_err_o),
   .sub_err_o  (sub_err_o)
);

// File: tb/scaler_phase_gen_tb_top.sv
module scaler_phase_gen_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        in_vld_i = 1'b0;
   logic [31:0] scale_i = '0;
   logic [1:0]  sub_i = 2'd1;
   logic        cosite_i = 1'b0;
   logic [15:0] phase_o;
   logic        out_vld_o, range_err_o, sub_err_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   scaler_phase_gen dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .in_vld_i(in_vld_i), .scale_i(scale_i),
      .sub_i(sub_i), .cosite_i(cosite_i), .phase_o(phase_o),
      .out_vld_o(out_vld_o), .range_err_o(range_err_o), .sub_err_o(sub_err_o)
   );

   function automatic longint ref_v(logic [31:0] sc, logic [1:0] sb, logic cs);
      longint v = -32768;
      longint s = (sb == 2'd2) ? 2 : 1;
      if (cs && sb == 2'd2) v += 16384;
      v += longint'(sc) / (2 * s);
      return v;
   endfunction

   function automatic logic [15:0] ref_word(longint v);
      longint w = (v < 0) ? v + 65536 : v;
      logic [15:0] f = 16'((w >> 2) & 32'h7fff);
      return (v >= 0) ? (f | 16'h8000) : f;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] sc, logic [1:0] sb, logic cs, string tag);
      longint v;
      @(negedge clk_i);
      scale_i = sc; sub_i = sb; cosite_i = cs; in_vld_i = 1'b1;
      @(negedge clk_i);
      in_vld_i = 1'b0;
      v = ref_v(sc, sb, cs);
      check({tag, " R2 valid"}, out_vld_o, 1);
      check({tag, (v < 0) ? " R5 word" : " R6 word"}, phase_o, ref_word(v));
      check({tag, " R7 range"}, range_err_o, (v < -32768 || v > 98304) ? 1 : 0);
      check({tag, " R8 suberr"}, sub_err_o, (sb != 2'd1 && sb != 2'd2) ? 1 : 0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk_i);
      check("R1 vld", out_vld_o, 0);
      check("R1 phase", phase_o, 0);
      check("R1 flags", {range_err_o, sub_err_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1 vld after release", out_vld_o, 0);

      apply(32'h40000, 2'd1, 1'b0, "R9 down4");
      check("R9 down4 value", phase_o, 16'hE000);
      apply(32'h4000, 2'd1, 1'b0, "R9 up4");
      check("R9 up4 value", phase_o, 16'h2800);
      apply(32'h0, 2'd2, 1'b0, "R3 zero s2");
      check("R3 zero s2 value", phase_o, 16'h2000);
      apply(32'h0, 2'd2, 1'b1, "R4 cosite s2");
      check("R4 cosite s2 value", phase_o, 16'h3000);
      apply(32'h0, 2'd1, 1'b1, "R4 cosite s1");
      check("R4 cosite s1 value", phase_o, 16'h2000);
      apply(32'h10000, 2'd1, 1'b0, "R6 unity");
      check("R6 unity value", phase_o, 16'h8000);
      apply(32'h40001, 2'd1, 1'b0, "R7 edge");
      check("R7 edge flag", range_err_o, 0);
      apply(32'h40002, 2'd1, 1'b0, "R7 over");
      check("R7 over flag", range_err_o, 1);
      apply(32'h80000, 2'd3, 1'b1, "R8 bad3");
      apply(32'h20000, 2'd0, 1'b0, "R8 bad0");

      held = phase_o;
      @(negedge clk_i);
      scale_i = 32'h12345; sub_i = 2'd2; cosite_i = 1'b1;
      @(negedge clk_i);
      check("R10 hold phase", phase_o, held);
      check("R2 idle vld", out_vld_o, 0);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] sc;
         int pick = $urandom % 8;
         if (pick < 5) sc = $urandom % 32'h60000;
         else if (pick < 7) sc = 32'h3FFF0 + ($urandom % 32);
         else sc = $urandom;
         apply(sc, 2'($urandom), 1'($urandom), "rand R3");
         if ($urandom % 4 == 0) begin
            held = phase_o;
            @(negedge clk_i);
            scale_i = $urandom;
            @(negedge clk_i);
            check("rand R10 hold", phase_o, held);
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule